// File: doc/BRIEF.md
# Real-Time Counter with Alarm and Periodic Tick

This block is a timer peripheral for a low-power chip. It keeps a 40-bit free-running count that advances once for every pulse on `rtc_step`. In a system, `rtc_step` is a one-cycle strobe at 32.768 kHz, so the elapsed seconds are count bits [39:15]. Software reads the count as two words: a 32-bit low part and an 8-bit high part. Each part has its own freeze control. A clear control holds the whole count at zero for as long as it stays set.

The block raises three events. A rollover event occurs when the full count wraps to zero. An alarm event occurs when a counting step lands on a programmed 40-bit compare value. A periodic tick comes from a separate reloading down-counter, which advances on `tmr_step`. All three events latch into one status word, and each latched bit also drives an interrupt line.

Software reaches every register through a single-cycle register bus. A write takes effect at the clock edge where `bus_sel` and `bus_wr` are both high. A read returns the live value of the addressed register combinationally. Word addresses are: 0 control, 1 count low, 2 count high, 3 alarm low, 4 alarm high, 5 tick period, 6 status.

Top module: `rtc_timer_unit`

## Requirements
- R1: After reset the count, the control word, the alarm, the period and the status all read as zero.
- R2: Each `rtc_step` pulse adds one to the 40-bit count. The low 32 bits read at address 1, and the high 8 bits read at address 2 in bits [7:0]. A wrap of the low part carries into the high part.
- R3: Control bit 2 freezes the low part and control bit 1 freezes the high part. A frozen part keeps its value. While the high part is frozen, a wrap of the low part does not carry into it.
- R4: Control bit 0 forces the count to zero and holds it there, ignoring steps. Counting resumes from zero once software writes the bit back to 0.
- R5: Control bit 3 enables the periodic counter and bit 4 freezes it. While disabled, the counter holds the period from address 5. When enabled and not frozen, each `tmr_step` counts it down. A step taken at zero raises the tick and reloads, so ticks are period+1 steps apart.
- R6: Status bit 31 is set when a step wraps the full count from all ones to zero.
- R7: Status bit 30 is set when a step brings the count to the 40-bit value formed by address 4 (high, bits [7:0]) and address 3 (low).
- R8: Status bits 31, 30 and 29 (bit 29 is the tick) stay set until software writes 1 to them at address 6. Writing 0 leaves them unchanged. Outputs `irq_wrap`, `irq_alarm` and `irq_tick` follow these bits.
- R9: Reads return live values, and two reads with no step between them return the same value.
- R10: Writing 0 to the control word deasserts every enable, freeze and clear bit, and the control word reads back 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and logic clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rtc_step | input | 1 | One-cycle strobe that advances the count |
| tmr_step | input | 1 | One-cycle strobe that advances the periodic counter |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, live, zero when not reading |
| irq_wrap | output | 1 | Latched rollover event |
| irq_alarm | output | 1 | Latched alarm event |
| irq_tick | output | 1 | Latched periodic tick |

## Verification
The assertions check several rules on every cycle. A clear leaves the count at zero on the next cycle. A frozen part holds its value. A wrap lands on zero. An alarm hit lands on the compare value. A tick reloads the period. A status bit stays set unless a write-one clears it. Other behaviour can only be shown by the bench's scenarios, through register reads: carry into the high part, suppression of carry while the high part is frozen, full rollover (exercised on a narrow second instance), the exact step on which the alarm fires, the spacing between ticks, and agreement between back-to-back reads.

// File: rtl/rtc_timer_pkg.sv
package rtc_timer_pkg;
  localparam logic [2:0] A_CTRL   = 3'd0;
  localparam logic [2:0] A_CNT_LO = 3'd1;
  localparam logic [2:0] A_CNT_HI = 3'd2;
  localparam logic [2:0] A_ALM_LO = 3'd3;
  localparam logic [2:0] A_ALM_HI = 3'd4;
  localparam logic [2:0] A_PERIOD = 3'd5;
  localparam logic [2:0] A_STAT   = 3'd6;

  localparam int CTRL_W = 5;
  localparam int ST_WRAP  = 31;
  localparam int ST_ALARM = 30;
  localparam int ST_TICK  = 29;

  typedef struct packed {
    logic per_frz;
    logic per_en;
    logic frz_lo;
    logic frz_hi;
    logic clr;
  } ctrl_t;
endpackage

// File: rtl/rtc_count40.sv
module rtc_count40 #(
  parameter int LO_W = 32,
  parameter int HI_W = 8,
  localparam int TW = LO_W + HI_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            step,
  input  logic            clr,
  input  logic            frz_lo,
  input  logic            frz_hi,
  output logic [LO_W-1:0] lo,
  output logic [HI_W-1:0] hi,
  output logic [TW-1:0]   nxt,
  output logic            moved,
  output logic            wrap
);
  function automatic logic [LO_W-1:0] lo_inc(input logic [LO_W-1:0] v);
    return v + LO_W'(1);
  endfunction
  function automatic logic [HI_W-1:0] hi_inc(input logic [HI_W-1:0] v);
    return v + HI_W'(1);
  endfunction

  logic            lo_carry;
  logic [LO_W-1:0] lo_n;
  logic [HI_W-1:0] hi_n;

  always_comb begin
    moved    = step && !clr && !frz_lo;
    lo_carry = moved && (&lo);
    lo_n     = moved ? lo_inc(lo) : lo;
    hi_n     = (lo_carry && !frz_hi) ? hi_inc(hi) : hi;
    wrap     = lo_carry && !frz_hi && (&hi);
    nxt      = {hi_n, lo_n};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo <= '0;
      hi <= '0;
    end else if (clr) begin
      lo <= '0;
      hi <= '0;
    end else begin
      lo <= lo_n;
      hi <= hi_n;
    end
  end

  p_clear_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (lo == '0 && hi == '0));
  p_freeze_lo_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (frz_lo && !clr) |=> $stable(lo));
  p_freeze_hi_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (frz_hi && !clr) |=> $stable(hi));
  p_wrap_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (lo == '0 && hi == '0));
  p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !clr) |=> ($stable(lo) && $stable(hi)));
endmodule

// File: rtl/rtc_alarm_cmp.sv
module rtc_alarm_cmp #(
  parameter int W = 40
) (
  input  logic         adv,
  input  logic [W-1:0] nxt,
  input  logic [W-1:0] target,
  output logic         hit
);
  function automatic logic lands_on(input logic [W-1:0] a, input logic [W-1:0] b);
    return (a ^ b) == '0;
  endfunction

  always_comb hit = adv && lands_on(nxt, target);
endmodule

// File: rtl/rtc_tick_gen.sv
module rtc_tick_gen #(
  parameter int PW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          frz,
  input  logic          step,
  input  logic [PW-1:0] period,
  output logic          tick,
  output logic [PW-1:0] cnt
);
  function automatic logic [PW-1:0] dec(input logic [PW-1:0] v);
    return v - PW'(1);
  endfunction

  logic live;
  always_comb begin
    live = en && !frz && step;
    tick = live && (cnt == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (!en)    cnt <= period;
    else if (tick)   cnt <= period;
    else if (live)   cnt <= dec(cnt);
  end

  p_tick_reload_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (cnt == $past(period)));
  p_freeze_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (en && frz) |=> $stable(cnt));
  p_off_loaded_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (cnt == $past(period)));
endmodule

// File: rtl/rtc_timer_unit.sv
module rtc_timer_unit
  import rtc_timer_pkg::*;
#(
  parameter int LO_W = 32,
  parameter int HI_W = 8,
  parameter int PW   = 16,
  localparam int TW  = LO_W + HI_W
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rtc_step,
  input  logic        tmr_step,
  input  logic        bus_sel,
  input  logic        bus_wr,
  input  logic [2:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        irq_wrap,
  output logic        irq_alarm,
  output logic        irq_tick
);
  ctrl_t           ctrl;
  logic [LO_W-1:0] alm_lo;
  logic [HI_W-1:0] alm_hi;
  logic [PW-1:0]   period;
  logic [2:0]      stat;     // {wrap, alarm, tick}

  logic [LO_W-1:0] cnt_lo;
  logic [HI_W-1:0] cnt_hi;
  logic [TW-1:0]   cnt_nxt;
  logic            cnt_moved, ev_wrap, ev_alarm, ev_tick;
  logic [PW-1:0]   per_cnt;

  logic            wr_en;
  logic [2:0]      ev_set, w1c;

  rtc_count40 #(.LO_W(LO_W), .HI_W(HI_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .step(rtc_step), .clr(ctrl.clr),
    .frz_lo(ctrl.frz_lo), .frz_hi(ctrl.frz_hi),
    .lo(cnt_lo), .hi(cnt_hi), .nxt(cnt_nxt), .moved(cnt_moved), .wrap(ev_wrap)
  );

  rtc_alarm_cmp #(.W(TW)) u_alm (
    .adv(cnt_moved), .nxt(cnt_nxt), .target({alm_hi, alm_lo}), .hit(ev_alarm)
  );

  rtc_tick_gen #(.PW(PW)) u_per (
    .clk(clk), .rst_n(rst_n), .en(ctrl.per_en), .frz(ctrl.per_frz),
    .step(tmr_step), .period(period), .tick(ev_tick), .cnt(per_cnt)
  );

  always_comb begin
    wr_en  = bus_sel && bus_wr;
    ev_set = {ev_wrap, ev_alarm, ev_tick};
    w1c    = (wr_en && bus_addr == A_STAT) ?
             {bus_wdata[ST_WRAP], bus_wdata[ST_ALARM], bus_wdata[ST_TICK]} : 3'b000;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl   <= '0;
      alm_lo <= '0;
      alm_hi <= '0;
      period <= '0;
    end else if (wr_en) begin
      case (bus_addr)
        A_CTRL:   ctrl   <= ctrl_t'(bus_wdata[CTRL_W-1:0]);
        A_ALM_LO: alm_lo <= bus_wdata[LO_W-1:0];
        A_ALM_HI: alm_hi <= bus_wdata[HI_W-1:0];
        A_PERIOD: period <= bus_wdata[PW-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat <= '0;
    else        stat <= (stat & ~w1c) | ev_set;
  end

  always_comb begin
    logic [31:0] v;
    v = '0;
    case (bus_addr)
      A_CTRL:   v[CTRL_W-1:0] = ctrl;
      A_CNT_LO: v[LO_W-1:0]   = cnt_lo;
      A_CNT_HI: v[HI_W-1:0]   = cnt_hi;
      A_ALM_LO: v[LO_W-1:0]   = alm_lo;
      A_ALM_HI: v[HI_W-1:0]   = alm_hi;
      A_PERIOD: v[PW-1:0]     = period;
      A_STAT: begin
        v[ST_WRAP]  = stat[2];
        v[ST_ALARM] = stat[1];
        v[ST_TICK]  = stat[0];
      end
      default: ;
    endcase
    bus_rdata = (bus_sel && !bus_wr) ? v : 32'h0;
  end

  assign irq_wrap  = stat[2];
  assign irq_alarm = stat[1];
  assign irq_tick  = stat[0];

  p_alarm_lands_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_alarm |=> ({cnt_hi, cnt_lo} == $past({alm_hi, alm_lo})));
  p_w1c_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (w1c[1] && !ev_set[1]) |=> !irq_alarm);
  p_sticky_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_wrap && !w1c[2]) |=> irq_wrap);
  p_sticky_tick_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_tick && !w1c[0]) |=> irq_tick);
  p_ctrl_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && bus_addr == A_CTRL && bus_wdata[CTRL_W-1:0] == '0) |=> (ctrl == '0));
endmodule

// File: tb/sim_rtc_timer_unit.sv
`timescale 1ns/1ps
module sim_rtc_timer_unit;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        rtc_step = 0, tmr_step = 0;
  logic        bus_sel = 0, bus_wr = 0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] rd0, rd1;
  logic        wr0, al0, tk0, wr1, al1, tk1;

  always #2.5 clk = ~clk;

  rtc_timer_unit u0 (
    .clk(clk), .rst_n(rst_n), .rtc_step(rtc_step), .tmr_step(tmr_step),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(rd0), .irq_wrap(wr0), .irq_alarm(al0), .irq_tick(tk0)
  );

  // narrow instance: 6-bit count so that carry and rollover are reachable
  rtc_timer_unit #(.LO_W(4), .HI_W(2), .PW(16)) u1 (
    .clk(clk), .rst_n(rst_n), .rtc_step(rtc_step), .tmr_step(tmr_step),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(rd1), .irq_wrap(wr1), .irq_alarm(al1), .irq_tick(tk1)
  );

  typedef struct {
    logic [31:0] exp;
    string       tag;
    bit          which;
  } rd_item_t;

  rd_item_t    q[$];
  rd_item_t    item;
  logic [31:0] act;
  bit          rd_pend = 0;
  int          vecs = 0, miss = 0;
  bit          done = 0;

  // monitor: pops expected read items and compares against the bus
  always @(negedge clk) begin
    if (rd_pend && q.size() > 0) begin
      item = q.pop_front();
      act  = item.which ? rd1 : rd0;
      vecs++;
      if (act !== item.exp) begin
        miss++;
        $display("FAIL %s: got %h expected %h", item.tag, act, item.exp);
      end
    end
  end

  task automatic rd(input bit which, input logic [2:0] a, input logic [31:0] e, input string tag);
    rd_item_t it;
    @(posedge clk); #1;
    it.exp = e; it.tag = tag; it.which = which;
    q.push_back(it);
    bus_sel = 1; bus_wr = 0; bus_addr = a; rd_pend = 1;
    @(posedge clk); #1;
    bus_sel = 0; rd_pend = 0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rstep(input int n);
    @(posedge clk); #1;
    rtc_step = 1;
    repeat (n) @(posedge clk);
    #1 rtc_step = 0;
  endtask

  task automatic tstep(input int n);
    @(posedge clk); #1;
    tmr_step = 1;
    repeat (n) @(posedge clk);
    #1 tmr_step = 0;
  endtask

  task automatic chk_bit(input logic a, input logic e, input string tag);
    @(negedge clk);
    vecs++;
    if (a !== e) begin
      miss++;
      $display("FAIL %s: got %b expected %b", tag, a, e);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
      $finish;
    end
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    miss++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    // R1 reset state
    rd(0, 3'd0, 32'h0, "R1 ctrl");
    rd(0, 3'd1, 32'h0, "R1 cnt_lo");
    rd(0, 3'd2, 32'h0, "R1 cnt_hi");
    rd(0, 3'd4, 32'h0, "R1 alm_hi");
    rd(0, 3'd5, 32'h0, "R1 period");
    rd(0, 3'd6, 32'h0, "R1 status");

    // R2 counting, R9 coherent double read
    rstep(5);
    rd(0, 3'd1, 32'd5, "R2 count 5");
    rd(0, 3'd1, 32'd5, "R9 second read");
    rd(0, 3'd2, 32'd0, "R9 hi read");
    rd(0, 3'd2, 32'd0, "R9 hi reread");

    // R3 low freeze
    wr(3'd0, 32'h4);
    rstep(3);
    rd(0, 3'd1, 32'd5, "R3 lo frozen");
    wr(3'd0, 32'h0);
    rstep(2);
    rd(0, 3'd1, 32'd7, "R3 lo resumes");

    // R4 clear held, then resume
    wr(3'd0, 32'h1);
    rstep(4);
    rd(0, 3'd1, 32'd0, "R4 held at zero");
    rd(0, 3'd0, 32'h1, "R4 ctrl clear bit");
    wr(3'd0, 32'h0);
    rstep(3);
    rd(0, 3'd1, 32'd3, "R4 resume");
    rd(1, 3'd1, 32'd3, "R4 narrow resume");

    // R2 carry into high part (narrow)
    rstep(13);
    rd(1, 3'd1, 32'd0, "R2 narrow lo after carry");
    rd(1, 3'd2, 32'd1, "R2 narrow hi after carry");

    // R3 high freeze blocks carry
    wr(3'd0, 32'h2);
    rstep(16);
    rd(1, 3'd1, 32'd0, "R3 narrow lo wrapped");
    rd(1, 3'd2, 32'd1, "R3 narrow hi frozen");
    wr(3'd0, 32'h0);

    // R6 full rollover (narrow), alarm at 0 also hit
    rstep(48);
    rd(1, 3'd1, 32'd0, "R6 narrow lo zero");
    rd(1, 3'd2, 32'd0, "R6 narrow hi zero");
    rd(1, 3'd6, 32'hC000_0000, "R6 narrow status");
    chk_bit(wr1, 1'b1, "R8 irq_wrap narrow");
    rd(0, 3'd6, 32'h0, "R6 wide no rollover");
    rd(0, 3'd1, 32'd80, "R2 wide count 80");

    // R8 write-one-to-clear, selective
    wr(3'd6, 32'h8000_0000);
    rd(1, 3'd6, 32'h4000_0000, "R8 only wrap cleared");
    wr(3'd6, 32'h0);
    rd(1, 3'd6, 32'h4000_0000, "R8 zero write keeps");
    wr(3'd6, 32'h4000_0000);
    rd(1, 3'd6, 32'h0, "R8 alarm cleared");

    // R7 alarm
    wr(3'd3, 32'd90);
    wr(3'd4, 32'd0);
    rd(0, 3'd3, 32'd90, "R7 alm_lo readback");
    rstep(9);
    rd(0, 3'd6, 32'h0, "R7 not yet at 89");
    chk_bit(al0, 1'b0, "R7 irq_alarm low");
    rstep(1);
    rd(0, 3'd6, 32'h4000_0000, "R7 fired at 90");
    chk_bit(al0, 1'b1, "R8 irq_alarm high");
    rstep(3);
    rd(0, 3'd6, 32'h4000_0000, "R8 sticky");
    wr(3'd6, 32'hE000_0000);
    rd(0, 3'd6, 32'h0, "R8 all cleared");

    // R5 periodic tick
    wr(3'd5, 32'd4);
    wr(3'd0, 32'h8);
    tstep(4);
    rd(0, 3'd6, 32'h0, "R5 no tick after 4");
    tstep(1);
    rd(0, 3'd6, 32'h2000_0000, "R5 tick after 5");
    chk_bit(tk0, 1'b1, "R8 irq_tick high");
    wr(3'd6, 32'h2000_0000);
    tstep(4);
    rd(0, 3'd6, 32'h0, "R5 reload no early tick");
    tstep(1);
    rd(0, 3'd6, 32'h2000_0000, "R5 second tick");
    wr(3'd6, 32'h2000_0000);
    wr(3'd0, 32'h18);
    tstep(10);
    rd(0, 3'd6, 32'h0, "R5 frozen no tick");
    wr(3'd0, 32'h8);
    tstep(5);
    rd(0, 3'd6, 32'h2000_0000, "R5 unfrozen tick");
    wr(3'd6, 32'h2000_0000);

    // R10 control word reset
    wr(3'd0, 32'h1F);
    rd(0, 3'd0, 32'h1F, "R10 all set");
    rd(0, 3'd1, 32'd0, "R10 clear active");
    wr(3'd0, 32'h0);
    rd(0, 3'd0, 32'h0, "R10 all deasserted");
    rstep(2);
    rd(0, 3'd1, 32'd2, "R10 counting again");
    rd(0, 3'd1, 32'd2, "R9 repeat read");

    repeat (4) @(posedge clk);
    finish_run();
  end
endmodule